// File: doc/BRIEF.md
# Filtered Status Register Node

This block is one node in a tree of instrument status registers. It watches a live vector of condition flags. For each flag, the host picks whether a rising edge, a falling edge, or both are recorded. A recorded edge sets a sticky bit in the event register. That bit stays set until the host reads the event register, and the read also clears it. The node ANDs the event register with an enable mask and ORs the result into one summary line. That line becomes one condition bit of the node one level up.

The host reaches the node through a small register port. One write strobe carries a 3-bit selector and a data word. The read selector drives the read data combinationally. A read strobe marks a read that has side effects. The most significant bit of each 16-bit word is reserved: it always reads as zero and can never record an event.

Top module: `stat_node`

## Requirements
- R1: With read selector 0, the read data shows the condition input in the same cycle, with no latching and with bit 15 forced to zero.
- R2: A 0-to-1 change of a condition bit, seen between two successive clock edges, sets that event bit when the bit's rising-filter mask (selector 3) is 1. If that mask bit is 0, the event bit is not set.
- R3: A 1-to-0 change of a condition bit sets its event bit when the bit's falling-filter mask (selector 4) is 1. When both masks are set for a bit, both edges are recorded.
- R4: A write to the enable mask (selector 2) loads the same value into the rising-filter mask. A write to selector 3 or 4 changes only that mask.
- R5: A read of the event register (selector 1) with the read strobe high returns all recorded edges. From the next clock edge on, those bits are zero. With the strobe low, selector 1 only shows the event register and leaves it unchanged.
- R6: The summary output is high exactly when some bit is set in both the event register and the enable mask.
- R7: A condition pulse that rises and falls between two event reads stays recorded until the next event read.
- R8: Bit 15 is reserved. It reads zero from every selector, writes to it are dropped, and it never sets an event.
- R9: If a qualifying edge arrives in the same cycle as an event read-clear, its event bit is still set after that clock edge.
- R10: A synchronous active-low reset clears the event register and all three masks to zero.
- R11: A condition bit that stays steady records nothing, so after a clear the event bit stays zero while the level is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_in | input | 16 | Live condition flags |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target: 2 enable, 3 rising filter, 4 falling filter |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe; with selector 1 it clears the event register |
| rd_sel | input | 3 | Read source: 0 condition, 1 event, 2 enable, 3 rising filter, 4 falling filter |
| rd_data | output | 16 | Read data, combinational from rd_sel |
| summary | output | 1 | OR of event AND enable, to the parent node |

## Verification
The embedded assertions check several rules on every cycle:
- a recorded edge appears in the event register even when a clear falls in the same cycle;
- with no clear, event bits only accumulate;
- a clear removes every bit that was not set again;
- a write to the enable mask mirrors into the rising filter;
- the reserved bit reads zero;
- the summary is never high while the event register is empty.

Only the bench scenarios can show the rest:
- which edge direction each mask selects;
- that a short pulse between reads is kept;
- that a held level records nothing;
- the values read back after reset.

// File: rtl/stnode_pkg.sv
// Shared register selector codes for the status node.
package stnode_pkg;
    typedef enum logic [2:0] {
        SEL_COND   = 3'd0,
        SEL_EVENT  = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_RISE   = 3'd3,
        SEL_FALL   = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/stnode_masks.sv
// Holds the enable, rising-filter and falling-filter masks.
// Assumes the write data are already valid in the cycle of the write strobe.
// The reserved top bit is forced to zero on every write.
module stnode_masks
    import stnode_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] en_q,
    output logic [WIDTH-1:0] rise_q,
    output logic [WIDTH-1:0] fall_q
);
    localparam logic [WIDTH-1:0] USE_MASK = {1'b0, {(WIDTH-1){1'b1}}};

    logic [WIDTH-1:0] data_m;
    assign data_m = wr_data & USE_MASK;

    // Mask update: an enable write also loads the rising filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ENABLE: begin
                    en_q   <= data_m;
                    rise_q <= data_m;
                end
                SEL_RISE: rise_q <= data_m;
                SEL_FALL: fall_q <= data_m;
                default:  ;
            endcase
        end
    end

    // R4: an enable write leaves both masks holding the same value
    a_r4_enable_mirrors_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ENABLE) |=> (rise_q == en_q));
endmodule

// File: rtl/stnode_edges.sv
// Compares the condition vector with its copy from one clock earlier.
// Keeps each edge that its direction mask selects.
// Assumes cond_m is synchronous to clk.
module stnode_edges #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cond_m,
    input  logic [WIDTH-1:0] rise_q,
    input  logic [WIDTH-1:0] fall_q,
    output logic [WIDTH-1:0] set_vec
);
    logic [WIDTH-1:0] cond_q;

    // Previous-cycle copy of the conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond_m;
    end

    // Per-bit filter: the rising or falling edge, each gated by its own mask.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            set_vec[i] = (cond_m[i] & ~cond_q[i] & rise_q[i]) |
                         (~cond_m[i] & cond_q[i] & fall_q[i]);
        end
    end

    // R11: a bit whose condition has not moved produces no set request
    a_r11_steady_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & ~(cond_m ^ cond_q)) == '0));
endmodule

// File: rtl/stnode_events.sv
// Sticky event register: set requests accumulate, and a read-clear empties it.
// When a set and a clear fall in the same cycle, the set wins.
module stnode_events #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic             clr,
    output logic [WIDTH-1:0] evt_q
);
    // Event accumulation, with the same-cycle edge overriding the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (clr ? '0 : evt_q) | set_vec;
    end

    // R9, R2: every set request is visible after the edge
    a_r9_set_survives_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((evt_q & $past(set_vec)) == $past(set_vec)));
    // R7: with no clear, bits already recorded stay recorded
    a_r7_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
    // R5: a clear removes every bit that was not set again
    a_r5_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((evt_q & ~$past(set_vec)) == '0));
endmodule

// File: rtl/stat_node.sv
// One status node: condition view, edge filters, sticky events, enable
// mask and summary line. Assumes host strobes last one cycle each.
// Bit WIDTH-1 is reserved and is held at zero throughout.
module stat_node
    import stnode_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cond_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [2:0]       rd_sel,
    output logic [WIDTH-1:0] rd_data,
    output logic             summary
);
    localparam logic [WIDTH-1:0] USE_MASK = {1'b0, {(WIDTH-1){1'b1}}};

    logic [WIDTH-1:0] cond_m, en_q, rise_q, fall_q, set_vec, evt_q;
    logic             evt_clr;

    assign cond_m  = cond_in & USE_MASK;
    assign evt_clr = rd_en && (rd_sel == SEL_EVENT);

    stnode_masks #(.WIDTH(WIDTH)) u_masks (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .en_q(en_q), .rise_q(rise_q), .fall_q(fall_q)
    );

    stnode_edges #(.WIDTH(WIDTH)) u_edges (
        .clk(clk), .rst_n(rst_n), .cond_m(cond_m), .rise_q(rise_q),
        .fall_q(fall_q), .set_vec(set_vec)
    );

    stnode_events #(.WIDTH(WIDTH)) u_events (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr(evt_clr),
        .evt_q(evt_q)
    );

    // Read mux selected by rd_sel.
    always_comb begin
        case (rd_sel)
            SEL_COND:   rd_data = cond_m;
            SEL_EVENT:  rd_data = evt_q;
            SEL_ENABLE: rd_data = en_q;
            SEL_RISE:   rd_data = rise_q;
            SEL_FALL:   rd_data = fall_q;
            default:    rd_data = '0;
        endcase
    end

    // Summary: the enabled events OR-reduced for the parent node.
    assign summary = |(evt_q & en_q);

    // R8: the reserved bit never reaches the read port
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WIDTH-1] == 1'b0);
    // R6: no summary while the event register is empty
    a_r6_summary_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        summary |-> (evt_q != '0));
endmodule

// File: tb/stat_node_test.sv
module stat_node_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cond_in;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic        rd_en;
    logic [2:0]  rd_sel;
    logic [15:0] rd_data;
    logic        summary;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stat_node uut (
        .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .summary(summary)
    );

    // Behavioural reference state.
    logic [15:0] m_prev, m_evt, m_en, m_rise, m_fall;
    localparam logic [15:0] KEEP = 16'h7FFF;

    always @(posedge clk) begin
        logic [15:0] c, edges;
        if (!rst_n) begin
            m_prev = 0; m_evt = 0; m_en = 0; m_rise = 0; m_fall = 0;
        end else begin
            c = cond_in & KEEP;
            edges = (c & ~m_prev & m_rise) | (~c & m_prev & m_fall);
            if (rd_en && rd_sel == 3'd1) m_evt = 0;
            m_evt = m_evt | edges;
            if (wr_en) begin
                if (wr_sel == 3'd2) begin m_en = wr_data & KEEP; m_rise = wr_data & KEEP; end
                else if (wr_sel == 3'd3) m_rise = wr_data & KEEP;
                else if (wr_sel == 3'd4) m_fall = wr_data & KEEP;
            end
            m_prev = c;
        end
    end

    function automatic logic [15:0] exp_rd();
        case (rd_sel)
            3'd0: return cond_in & KEEP;
            3'd1: return m_evt;
            3'd2: return m_en;
            3'd3: return m_rise;
            3'd4: return m_fall;
            default: return 16'h0;
        endcase
    endfunction

    // One cycle: outputs checked 1 ns after inputs change at the falling edge.
    task automatic cyc(input string tag);
        #1;
        checks++;
        if (rd_data !== exp_rd()) begin
            errors++;
            $display("FAIL %s rd_sel=%0d rd_data actual=%h expected=%h", tag, rd_sel, rd_data, exp_rd());
        end
        checks++;
        if (summary !== |(m_evt & m_en)) begin
            errors++;
            $display("FAIL R6 (%s) summary actual=%b expected=%b", tag, summary, |(m_evt & m_en));
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d, input string tag);
        wr_en = 1; wr_sel = s; wr_data = d;
        cyc(tag);
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] s, input logic strobe, input string tag);
        rd_en = strobe; rd_sel = s;
        cyc(tag);
        rd_en = 0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; cond_in = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_en = 0; rd_sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R10: reset values of all registers
        rd(3'd1, 0, "R10 event"); rd(3'd2, 0, "R10 enable");
        rd(3'd3, 0, "R10 rise"); rd(3'd4, 0, "R10 fall");
        // R1: live condition view
        cond_in = 16'h1234; rd(3'd0, 0, "R1 cond");
        cond_in = 16'h0000; rd(3'd0, 0, "R1 cond");
        // R4: an enable write mirrors into the rising filter
        wr(3'd2, 16'h0013, "R4 enable write");
        rd(3'd3, 0, "R4 rise mirror"); rd(3'd2, 0, "R4 enable");
        wr(3'd3, 16'h0007, "R4 rise only");
        rd(3'd2, 0, "R4 enable kept"); rd(3'd3, 0, "R4 rise");
        rd(3'd4, 0, "R4 fall untouched");
        // R2: a rising edge on bit 0 with its filter set
        rd_sel = 3'd1;
        cond_in = 16'h0001; cyc("R2 rise bit0"); cyc("R2 event seen");
        // R2: a rising edge on bit 3 with its filter clear records nothing
        cond_in = 16'h0009; cyc("R2 masked rise"); cyc("R2 masked rise");
        // R5: read-clear, then empty
        rd(3'd1, 1, "R5 read returns"); rd(3'd1, 0, "R5 cleared");
        // R11: a held level does not re-record
        idle(3, "R11 steady");
        // R7: a one-cycle pulse on bit 1 between reads
        cond_in = 16'h000B; cyc("R7 pulse high");
        cond_in = 16'h0009; idle(4, "R7 held");
        rd(3'd1, 1, "R7 read"); rd(3'd1, 0, "R7 cleared");
        // R3: falling filter on bit 0; both edges on bit 0
        wr(3'd4, 16'h0001, "R3 fall write");
        cond_in = 16'h0008; rd(3'd1, 0, "R3 fall edge"); rd(3'd1, 0, "R3 fall seen");
        rd(3'd1, 1, "R3 clear");
        cond_in = 16'h0009; rd(3'd1, 0, "R3 both rise"); rd(3'd1, 1, "R3 both rise seen");
        cond_in = 16'h0008; rd(3'd1, 0, "R3 both fall"); rd(3'd1, 0, "R3 both fall seen");
        rd(3'd1, 1, "R3 clear");
        // R8: the reserved bit
        wr(3'd2, 16'hFFFF, "R8 enable all"); rd(3'd2, 0, "R8 enable"); rd(3'd3, 0, "R8 rise");
        wr(3'd4, 16'hFFFF, "R8 fall all"); rd(3'd4, 0, "R8 fall");
        cond_in = 16'h8008; rd(3'd0, 0, "R8 cond"); rd(3'd1, 0, "R8 no event");
        cond_in = 16'h0008; rd(3'd1, 0, "R8 no event");
        // R9: an edge in the same cycle as a read-clear
        rd(3'd1, 1, "R9 clear");
        cond_in = 16'h0018; rd(3'd1, 1, "R9 edge with clear");
        rd(3'd1, 0, "R9 edge kept"); rd(3'd1, 0, "R9 edge kept");
        // R6: summary follows the enable mask
        wr(3'd2, 16'h0000, "R6 disable"); rd(3'd1, 0, "R6 summary low");
        wr(3'd2, 16'h0010, "R6 enable bit4"); rd(3'd1, 0, "R6 summary high");
        rd(3'd1, 1, "R6 clear"); rd(3'd1, 0, "R6 summary low");
        // R10: a reset in mid-run
        rst_n = 0; cond_in = 16'h0000; cyc("R10 reset");
        rst_n = 1;
        rd(3'd1, 0, "R10 event"); rd(3'd2, 0, "R10 enable"); rd(3'd4, 0, "R10 fall");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule